// File: doc/BRIEF.md
# Receive Descriptor Ring DMA Engine

This engine moves received Ethernet frames from a byte stream into host buffers. The host builds a closed chain of descriptors in a word-addressed memory, sets a list pointer register to the first one, and raises the enable. The engine then reads the current descriptor. If its status word is zero, the engine takes the buffer size, the buffer word address and the link to the following descriptor, and waits for a frame.

Frame bytes are packed four per memory word, least significant lane first, from the buffer address upward. When the end marker arrives, the engine writes a status word. That word carries the stored byte count, the error flags, an end-of-packet bit and a done bit, and so hands the descriptor back to the host. The engine then follows the link. A descriptor whose status is not zero is still held by the host. The engine re-reads it on a timer set by an 8-bit poll period. A frame that begins while no free descriptor is ready is discarded whole and counted.

Top module: `rx_desc_dma`

## Requirements
- R1: In reset, and after reset while `rx_enable` is low and no descriptor is held, the engine makes no memory access and `drop_count` is 0.
- R2: A descriptor at word address D is laid out as follows: D+0 holds the link to the next descriptor, D+1 the status, D+2 the buffer size in bytes (bits 12:0, other bits ignored), and D+3 the buffer word address. On enable, the engine starts at the address written through `lp_wr`/`lp_data`.
- R3: A descriptor whose status word is not zero is not used. Its status word is read again every N*POLL_UNIT+3 cycles, where N is `poll_period`.
- R4: Byte k of a frame is stored in buffer word k/4 at bits 8*(k%4)+7:8*(k%4). The lanes of a final partial word above the last byte are written as zero.
- R5: On the end byte, the status word is written as follows: bits 12:0 hold the stored length, bit 14 and bit 15 (done) are 1, bit 16 is the overflow flag, bits 20:17 hold `rx_err` as sampled with the end byte, and all other bits are 0.
- R6: After completion, the next descriptor is the one named by the link word, so the chain wraps back to its first entry.
- R7: In a frame longer than the buffer size, only the first size bytes are stored, the length is the size, bit 16 is set, and no word beyond the buffer is written.
- R8: A frame whose start marker arrives while the engine holds no free descriptor (host-owned, fetching, writing status, or disabled) causes no memory write and raises `drop_count` by one.
- R9: `drop_count` saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_enable | input | 1 | Reception enable |
| lp_wr | input | 1 | Load the list pointer register |
| lp_data | input | ADDR_W | Word address of the first descriptor |
| poll_period | input | PERIOD_W | Retry interval in units of POLL_UNIT cycles |
| rx_valid | input | 1 | Byte valid on the receive stream |
| rx_sop | input | 1 | First byte of a frame |
| rx_eop | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Frame byte |
| rx_err | input | 4 | Error flags, sampled with the last byte |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the request |
| drop_count | output | DROP_W | Saturating count of discarded frames |

## Verification
The sharpest overlap is between the status write-back of one frame and the start marker of the next. The two can meet in one cycle when frames arrive back to back. The bench sends a second frame whose first byte directly follows the first frame's end byte. It then expects the first frame's status word to be complete and correct, the second frame to leave the next buffer untouched, and the drop count to rise by exactly one. A second overlap is between the poll timer and a host that frees the descriptor. The bench frees the descriptor while the engine is polling and expects the next frame to land in the wrapped-around buffer.

// File: rtl/rx_desc_dma_pkg.sv
package rx_desc_dma_pkg;
  localparam int LEN_W    = 13;
  localparam int ERR_W    = 4;
  localparam int EOP_BIT  = 14;
  localparam int DONE_BIT = 15;
  localparam int OVF_BIT  = 16;
  localparam int ERR_LSB  = 17;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD_STAT, ST_CHK, ST_LEN, ST_ADR, ST_NXT,
    ST_READY, ST_RECV, ST_WB, ST_POLL
  } rx_state_e;

  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len,
                                              input logic ovf,
                                              input logic [ERR_W-1:0] err);
    logic [31:0] s;
    s = '0;
    s[LEN_W-1:0]         = len;
    s[EOP_BIT]           = 1'b1;
    s[DONE_BIT]          = 1'b1;
    s[OVF_BIT]           = ovf;
    s[ERR_LSB +: ERR_W]  = err;
    return s;
  endfunction
endpackage

// File: rtl/rx_desc_packer.sv
module rx_desc_packer
  import rx_desc_dma_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              byte_vld,
  input  logic              last,
  input  logic [7:0]        din,
  input  logic [LEN_W-1:0]  size,
  input  logic [ADDR_W-1:0] base,
  output logic              wr,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [LEN_W-1:0]  len,
  output logic              ovf
);
  logic [LEN_W-1:0] cnt_q, cnt_cur;
  logic [31:0]      hold_q, hold_cur, merged;
  logic             ovf_q, ovf_cur, keep;
  logic [1:0]       lane;

  assign cnt_cur  = start ? '0 : cnt_q;
  assign hold_cur = start ? '0 : hold_q;
  assign ovf_cur  = start ? 1'b0 : ovf_q;
  assign keep     = byte_vld && (cnt_cur < size);
  assign lane     = cnt_cur[1:0];

  for (genvar i = 0; i < 4; i++) begin : g_lane
    assign merged[8*i +: 8] = (keep && lane == 2'(i)) ? din : hold_cur[8*i +: 8];
  end

  assign wr      = byte_vld && ((keep && lane == 2'd3) || (last && (keep || lane != 2'd0)));
  assign wr_addr = base + ADDR_W'(cnt_cur >> 2);
  assign wr_data = merged;
  assign len     = cnt_q;
  assign ovf     = ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
      ovf_q  <= 1'b0;
    end else if (byte_vld) begin
      cnt_q  <= cnt_cur + LEN_W'(keep);
      hold_q <= wr ? '0 : merged;
      ovf_q  <= ovf_cur | ~keep;
    end
  end
endmodule

// File: rtl/rx_desc_poll_timer.sv
module rx_desc_poll_timer #(
  parameter int PERIOD_W  = 8,
  parameter int POLL_UNIT = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [PERIOD_W-1:0] period,
  output logic                expired
);
  localparam int CW = PERIOD_W + $clog2(POLL_UNIT) + 1;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)              cnt_q <= '0;
    else if (load)        cnt_q <= CW'(period) * CW'(POLL_UNIT);
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/rx_desc_drop_ctr.sv
module rx_desc_drop_ctr #(
  parameter int DROP_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [DROP_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)                      count <= '0;
    else if (inc && count != '1)  count <= count + 1'b1;
  end
endmodule

// File: rtl/rx_desc_dma.sv
module rx_desc_dma
  import rx_desc_dma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int DROP_W    = 16,
  parameter int PERIOD_W  = 8,
  parameter int POLL_UNIT = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_enable,
  input  logic                lp_wr,
  input  logic [ADDR_W-1:0]   lp_data,
  input  logic [PERIOD_W-1:0] poll_period,
  input  logic                rx_valid,
  input  logic                rx_sop,
  input  logic                rx_eop,
  input  logic [7:0]          rx_data,
  input  logic [ERR_W-1:0]    rx_err,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [31:0]         mem_wdata,
  input  logic [31:0]         mem_rdata,
  output logic [DROP_W-1:0]   drop_count
);
  rx_state_e         st;
  logic [ADDR_W-1:0] lp_q, cur_q, nxt_q, buf_q;
  logic [LEN_W-1:0]  size_q;
  logic [ERR_W-1:0]  err_q;
  logic              dropping_q;
  logic              frame_start, accept, drop, byte_vld, busy_desc, poll_expired;
  logic              pk_wr, pk_ovf;
  logic [ADDR_W-1:0] pk_addr;
  logic [31:0]       pk_data;
  logic [LEN_W-1:0]  pk_len;

  assign frame_start = rx_valid && rx_sop && (st != ST_RECV) && !dropping_q;
  assign accept      = frame_start && (st == ST_READY) && rx_enable;
  assign drop        = frame_start && !accept;
  assign byte_vld    = rx_valid && (accept || st == ST_RECV);
  assign busy_desc   = (st == ST_CHK) && (mem_rdata != '0);

  rx_desc_packer #(.ADDR_W(ADDR_W)) u_pack (
    .clk(clk), .rst(rst), .start(accept), .byte_vld(byte_vld), .last(rx_eop),
    .din(rx_data), .size(size_q), .base(buf_q), .wr(pk_wr), .wr_addr(pk_addr),
    .wr_data(pk_data), .len(pk_len), .ovf(pk_ovf)
  );

  rx_desc_poll_timer #(.PERIOD_W(PERIOD_W), .POLL_UNIT(POLL_UNIT)) u_poll (
    .clk(clk), .rst(rst), .load(busy_desc), .period(poll_period), .expired(poll_expired)
  );

  rx_desc_drop_ctr #(.DROP_W(DROP_W)) u_drop (
    .clk(clk), .rst(rst), .inc(drop), .count(drop_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      lp_q       <= '0;
      cur_q      <= '0;
      nxt_q      <= '0;
      buf_q      <= '0;
      size_q     <= '0;
      err_q      <= '0;
      dropping_q <= 1'b0;
    end else begin
      if (lp_wr) lp_q <= lp_data;
      if (drop) dropping_q <= !rx_eop;
      else if (dropping_q && rx_valid && rx_eop) dropping_q <= 1'b0;
      if (byte_vld && rx_eop) err_q <= rx_err;
      unique case (st)
        ST_IDLE:    if (rx_enable) begin cur_q <= lp_q; st <= ST_RD_STAT; end
        ST_RD_STAT: st <= ST_CHK;
        ST_CHK:     st <= busy_desc ? ST_POLL : ST_LEN;
        ST_LEN:     begin size_q <= mem_rdata[LEN_W-1:0]; st <= ST_ADR; end
        ST_ADR:     begin buf_q <= mem_rdata[ADDR_W-1:0]; st <= ST_NXT; end
        ST_NXT:     begin nxt_q <= mem_rdata[ADDR_W-1:0]; st <= ST_READY; end
        ST_READY: begin
          if (accept)          st <= rx_eop ? ST_WB : ST_RECV;
          else if (!rx_enable) st <= ST_IDLE;
        end
        ST_RECV:    if (rx_valid && rx_eop) st <= ST_WB;
        ST_WB:      begin cur_q <= nxt_q; st <= ST_RD_STAT; end
        ST_POLL: begin
          if (!rx_enable)        st <= ST_IDLE;
          else if (poll_expired) st <= ST_RD_STAT;
        end
        default:    st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = cur_q;
    mem_wdata = pk_data;
    unique case (st)
      ST_RD_STAT: begin mem_en = 1'b1; mem_addr = cur_q + ADDR_W'(1); end
      ST_CHK:     begin mem_en = 1'b1; mem_addr = cur_q + ADDR_W'(2); end
      ST_LEN:     begin mem_en = 1'b1; mem_addr = cur_q + ADDR_W'(3); end
      ST_ADR:     begin mem_en = 1'b1; mem_addr = cur_q; end
      ST_READY, ST_RECV: begin
        mem_en   = pk_wr;
        mem_we   = pk_wr;
        mem_addr = pk_addr;
      end
      ST_WB: begin
        mem_en    = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_q + ADDR_W'(1);
        mem_wdata = pack_status(pk_len, pk_ovf, err_q);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rx_desc_dma_chk.sv
module rx_desc_dma_chk
  import rx_desc_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DROP_W = 16
) (
  input logic              clk,
  input logic              rst,
  input rx_state_e         st,
  input logic              mem_en,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [31:0]       mem_wdata,
  input logic [ADDR_W-1:0] buf_q,
  input logic [LEN_W-1:0]  size_q,
  input logic [DROP_W-1:0] drop_count
);
  logic [ADDR_W-1:0] off, lim;
  assign off = mem_addr - buf_q;
  assign lim = (ADDR_W'(size_q) + ADDR_W'(3)) >> 2;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    st == ST_IDLE |-> !mem_en);

  assert_we_has_en_R4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en && (st == ST_READY || st == ST_RECV || st == ST_WB));

  assert_status_done_R5: assert property (@(posedge clk) disable iff (rst)
    st == ST_WB |-> mem_we && mem_wdata[DONE_BIT] && mem_wdata[EOP_BIT]);

  assert_len_capped_R7: assert property (@(posedge clk) disable iff (rst)
    st == ST_WB |-> mem_wdata[LEN_W-1:0] <= size_q);

  assert_wr_in_buf_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we && st != ST_WB |-> off < lim);

  assert_drop_step_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (drop_count - $past(drop_count)) <= DROP_W'(1));

  assert_drop_mono_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> drop_count >= $past(drop_count));
endmodule

bind rx_desc_dma rx_desc_dma_chk #(.ADDR_W(ADDR_W), .DROP_W(DROP_W)) u_chk (
  .clk(clk), .rst(rst), .st(st), .mem_en(mem_en), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .buf_q(buf_q), .size_q(size_q),
  .drop_count(drop_count)
);

// File: tb/test_rx_desc_dma.sv
module test_rx_desc_dma;
  localparam int AW = 16;
  localparam int DW = 3;
  localparam int UNIT = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, rx_enable, lp_wr, rx_valid, rx_sop, rx_eop;
  logic [AW-1:0] lp_data;
  logic [7:0]    poll_period, rx_data;
  logic [3:0]    rx_err;
  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata, mem_rdata;
  logic [DW-1:0] drop_count;

  rx_desc_dma #(.ADDR_W(AW), .DROP_W(DW), .PERIOD_W(8), .POLL_UNIT(UNIT)) i_rx_desc_dma (
    .clk(clk), .rst(rst), .rx_enable(rx_enable), .lp_wr(lp_wr), .lp_data(lp_data),
    .poll_period(poll_period), .rx_valid(rx_valid), .rx_sop(rx_sop), .rx_eop(rx_eop),
    .rx_data(rx_data), .rx_err(rx_err), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .drop_count(drop_count)
  );

  logic [31:0] mem [256];
  int cyc = 0, prev_rd = 0, last_rd = 0, quiet_hits = 0;
  bit quiet = 1'b0, done = 1'b0;
  int checks = 0, fails = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_en) begin
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      mem_rdata <= mem[mem_addr[7:0]];
      if (!mem_we && mem_addr == AW'(17)) begin
        prev_rd <= last_rd;
        last_rd <= cyc;
      end
    end
    if ((quiet || rst) && mem_en) quiet_hits <= quiet_hits + 1;
  end

  function automatic logic [31:0] pkw(logic [7:0] first, int n, int k);
    logic [31:0] w = '0;
    for (int j = 0; j < 4; j++)
      if (4*k + j < n) w[8*j +: 8] = first + 8'(4*k + j);
    return w;
  endfunction

  function automatic logic [31:0] stw(int len, bit ovf, logic [3:0] err);
    return 32'(len) | (32'd1 << 14) | (32'd1 << 15) | (32'(ovf) << 16) | (32'(err) << 17);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    rx_valid = 0; rx_sop = 0; rx_eop = 0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int n, logic [7:0] first, logic [3:0] err);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_valid = 1; rx_sop = (i == 0); rx_eop = (i == n - 1);
      rx_data = first + 8'(i); rx_err = err;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst = 1; rx_enable = 0; lp_wr = 0; lp_data = '0; poll_period = 8'd3;
    rx_valid = 0; rx_sop = 0; rx_eop = 0; rx_data = '0; rx_err = '0;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    mem[16] = 32'd32; mem[17] = 0; mem[18] = 32'h8000_0010; mem[19] = 32'h80;
    mem[32] = 32'd48; mem[33] = 0; mem[34] = 32'h8000_0008; mem[35] = 32'h90;
    mem[48] = 32'd16; mem[49] = 0; mem[50] = 32'h8000_0600; mem[51] = 32'hA0;
    mem[8'h92] = 32'hDEAD_BEEF;
    repeat (5) @(negedge clk);
    rst = 0; quiet = 1;
    repeat (20) @(negedge clk);
    check("R1 reset drop count", 32'(drop_count), 0);
    check("R1 no access while idle", quiet_hits, 0);
    quiet = 0;
    lp_data = AW'(16); lp_wr = 1;
    @(negedge clk); lp_wr = 0; rx_enable = 1;
    repeat (12) @(negedge clk);

    send(6, 8'h11, 4'h0); idle(20);
    check("R2 R4 word0", mem[8'h80], pkw(8'h11, 6, 0));
    check("R4 partial word", mem[8'h81], pkw(8'h11, 6, 1));
    check("R5 status", mem[17], stw(6, 0, 4'h0));

    send(11, 8'h21, 4'h5); idle(20);
    check("R7 word0", mem[8'h90], pkw(8'h21, 8, 0));
    check("R7 word1", mem[8'h91], pkw(8'h21, 8, 1));
    check("R7 no spill", mem[8'h92], 32'hDEAD_BEEF);
    check("R5 R7 status", mem[33], stw(8, 1, 4'h5));

    send(4, 8'h31, 4'h0); idle(20);
    check("R6 link followed", mem[8'hA0], pkw(8'h31, 4, 0));
    check("R6 status", mem[49], stw(4, 0, 4'h0));

    repeat (60) @(negedge clk);
    check("R3 poll interval", last_rd - prev_rd, 3 * UNIT + 3);

    send(5, 8'h41, 4'h0); idle(5);
    check("R8 drop while held", 32'(drop_count), 1);
    check("R8 buffer untouched", mem[8'h80], pkw(8'h11, 6, 0));

    mem[17] = 0; mem[33] = 0; mem[49] = 0;
    repeat (40) @(negedge clk);
    send(3, 8'hA1, 4'h0);
    send(4, 8'h51, 4'h0);
    idle(30);
    check("R6 wrap", mem[8'h80], pkw(8'hA1, 3, 0));
    check("R5 status after wrap", mem[17], stw(3, 0, 4'h0));
    check("R8 back-to-back drop", 32'(drop_count), 2);
    check("R8 next buffer untouched", mem[8'h90], pkw(8'h21, 8, 0));

    send(2, 8'h61, 4'h0); idle(20);
    check("R6 following descriptor", mem[8'h90], pkw(8'h61, 2, 0));
    check("R5 status short", mem[33], stw(2, 0, 4'h0));

    rx_enable = 0;
    repeat (5) @(negedge clk);
    quiet = 1;
    @(negedge clk);
    quiet_hits = 0;
    for (int f = 0; f < 7; f++) begin
      send(2, 8'h70, 4'h0); idle(2);
    end
    check("R9 saturation", 32'(drop_count), 7);
    check("R1 R8 no access disabled", quiet_hits, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule